// File: doc/BRIEF.md
# LPC Host Cycle Splitter

This block sits between a processor-side request port and a Low Pin Count style serial bus. It takes one memory or I/O request, read or write, one, two or four bytes wide, and runs it on the 4-bit multiplexed bus as a series of single-byte host cycles at ascending addresses. Read bytes come back one cycle at a time and are packed into one word. That word is handed back with a single completion pulse. A byte cycle that no peripheral claims is ended by the host, and that byte reads as 0xFF rather than raising an error.

The request side is a valid/ready handshake. `req_ready` is high only while the splitter is idle, so a requester under back-pressure holds its fields stable with `req_valid` high until `req_ready` rises. The completion side cannot be stalled. `cpl_valid` is high for exactly one clock, and `cpl_rdata` must be taken in that clock. A small stand-alone checker also flags bus-master transfer sizes that are not naturally aligned.

Top module: `lpc_cycle_splitter`

## Requirements
- R1: `req_ready` is high exactly when no request is in progress. A request is taken when `req_valid` and `req_ready` are both high. While a request is in progress, `req_valid` and the request fields have no effect on the bus.
- R2: `req_size` 00 gives one byte cycle, 01 gives two, and 10 or 11 gives four. Byte cycle i uses address `req_addr`+i, starting at i=0, and on writes it carries `req_wdata[8i+7:8i]`.
- R3: Each byte cycle starts with one clock in which `lframe_n` is low and `lad_out` is 0000. The next clock carries the type nibble: 0000 for an I/O read, 0010 for an I/O write, 0100 for a memory read and 0110 for a memory write.
- R4: The type nibble is followed by the address, most significant nibble first. An I/O cycle sends 4 nibbles (address bits 15:0) and a memory cycle sends 8. On writes, two data nibbles follow the address, low nibble first.
- R5: When the host's driving phase ends, two turnaround clocks follow with `lad_oe` low. `lad_oe` stays low through the sync, read-data and closing turnaround clocks.
- R6: During sync, a `lad_in` value of 0101 or 0110 is a wait and keeps the cycle open for any number of clocks. A value of 0000 means ready. On a read, two data nibbles then follow, low nibble first, and then two turnaround clocks.
- R7: If 4 consecutive sync clocks bring no valid sync value (0000, 0101 or 0110), the host drives one abort clock with `lframe_n` low and `lad_out` 1111. That byte reads as 0xFF, and the next byte cycle of the request still runs.
- R8: `cpl_valid` is high for exactly one clock, after the last byte cycle ends. On reads, byte i is placed in `cpl_rdata[8i+7:8i]` (little-endian). For writes `cpl_rdata` is zero, and for reads the lanes above the requested size are zero.
- R9: `lframe_n` is low only in start and abort clocks. In those clocks `lad_oe` is high and `lad_out` is 0000 or 1111. No other start encoding is ever driven.
- R10: `bm_misaligned` is high when `bm_size` is 01 and `bm_addr[0]` is 1, or when `bm_size` is 10 or 11 and `bm_addr` is not 00. It is never high for `bm_size` 00.
- R11: A new request can be accepted in the same clock in which `cpl_valid` reports the previous one. That acceptance disturbs neither the reported data nor the new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Splitter idle, request can be taken |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 = 1 byte, 01 = 2 bytes, 1x = 4 bytes |
| req_addr | input | 32 | Base byte address |
| req_wdata | input | 32 | Write data, byte 0 in bits 7:0 |
| cpl_valid | output | 1 | One-clock completion pulse |
| cpl_rdata | output | 32 | Packed read data |
| lad_out | output | 4 | Host nibble on the bus |
| lad_oe | output | 1 | Host drives the bus |
| lad_in | input | 4 | Nibble driven by the peripheral |
| lframe_n | output | 1 | Cycle framing strobe, active low |
| bm_size | input | 2 | Bus-master transfer size for the alignment check |
| bm_addr | input | 2 | Low two address bits of the bus-master transfer |
| bm_misaligned | output | 1 | Alignment violation |

## Verification
The two events that can fall in one clock are the completion pulse of one request and the acceptance of the next. This happens because `req_ready` rises in the same clock that `cpl_valid` is reported. The bench provokes it by raising `req_valid` with a second request while the first read is still on the bus. It then checks, at the `cpl_valid` clock, that `req_ready` is high and `cpl_rdata` holds the first read's value, and afterwards that the second request's bus cycle has the right type, address and data. Separately, waits longer than the abort window and wholly unclaimed multi-byte reads are run, to show that waits are never mistaken for silence.

// File: rtl/lpc_split_pkg.sv
package lpc_split_pkg;

  typedef enum logic [3:0] {
    B_IDLE,
    B_START,
    B_CTDIR,
    B_ADDR,
    B_WDATA,
    B_TARH,
    B_SYNC,
    B_RDATA,
    B_TARP,
    B_ABORT
  } bstate_e;

  localparam logic [3:0] NIB_START  = 4'b0000;
  localparam logic [3:0] NIB_ABORT  = 4'b1111;
  localparam logic [3:0] NIB_IDLE   = 4'b1111;
  localparam logic [3:0] SYNC_READY = 4'b0000;
  localparam logic [3:0] SYNC_SHORT = 4'b0101;
  localparam logic [3:0] SYNC_LONG  = 4'b0110;

  // type nibble: bit2 set for memory space, bit1 set for write
  function automatic logic [3:0] cyc_nib(input logic is_io, input logic is_wr);
    return {1'b0, ~is_io, is_wr, 1'b0};
  endfunction

endpackage

// File: rtl/lpc_align_check.sv
module lpc_align_check (
  input  logic [1:0] size,
  input  logic [1:0] addr_lo,
  output logic       misaligned
);

  always_comb begin
    unique case (size)
      2'b00:   misaligned = 1'b0;
      2'b01:   misaligned = addr_lo[0];
      default: misaligned = |addr_lo;
    endcase
  end

  always_comb begin
    if (size == 2'b00) begin
      a_r10_byte_never_flagged: assert (!misaligned);
    end
  end

endmodule

// File: rtl/lpc_byte_engine.sv
module lpc_byte_engine
  import lpc_split_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int TIMEOUT  = 4,
  parameter int TAR_CLKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              io,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic [3:0]        lad_in,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  output logic              lframe_n,
  output logic              byte_done,
  output logic [7:0]        byte_rdata
);

  localparam int MEM_NIBS = ADDR_W / 4;
  localparam int IO_NIBS  = 4;
  localparam int NIB_W    = $clog2(MEM_NIBS + TAR_CLKS + 1);
  localparam int TMO_W    = $clog2(TIMEOUT + 1);
  localparam logic [NIB_W-1:0] MEM_LAST = NIB_W'(MEM_NIBS - 1);
  localparam logic [NIB_W-1:0] IO_LAST  = NIB_W'(IO_NIBS - 1);
  localparam logic [NIB_W-1:0] TAR_LAST = NIB_W'(TAR_CLKS - 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT - 1);

  bstate_e          st;
  logic [NIB_W-1:0] nib_cnt;
  logic [TMO_W-1:0] tmo_cnt;
  logic [7:0]       rbyte;
  logic [NIB_W-1:0] addr_last;
  logic [ADDR_W-1:0] a_shift;
  logic             sync_wait;
  logic             sync_ok;

  assign addr_last = io ? IO_LAST : MEM_LAST;
  assign sync_wait = (lad_in == SYNC_SHORT) || (lad_in == SYNC_LONG);
  assign sync_ok   = sync_wait || (lad_in == SYNC_READY);
  assign a_shift   = addr >> {addr_last - nib_cnt, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= B_IDLE;
      nib_cnt <= '0;
      tmo_cnt <= '0;
      rbyte   <= '0;
    end else begin
      unique case (st)
        B_IDLE:  if (go) st <= B_START;
        B_START: st <= B_CTDIR;
        B_CTDIR: begin
          st      <= B_ADDR;
          nib_cnt <= '0;
        end
        B_ADDR: begin
          if (nib_cnt == addr_last) begin
            nib_cnt <= '0;
            st      <= wr ? B_WDATA : B_TARH;
          end else begin
            nib_cnt <= nib_cnt + 1'b1;
          end
        end
        B_WDATA: begin
          if (nib_cnt[0]) begin
            nib_cnt <= '0;
            st      <= B_TARH;
          end else begin
            nib_cnt <= nib_cnt + 1'b1;
          end
        end
        B_TARH: begin
          if (nib_cnt == TAR_LAST) begin
            nib_cnt <= '0;
            tmo_cnt <= '0;
            st      <= B_SYNC;
          end else begin
            nib_cnt <= nib_cnt + 1'b1;
          end
        end
        B_SYNC: begin
          if (lad_in == SYNC_READY) begin
            nib_cnt <= '0;
            st      <= wr ? B_TARP : B_RDATA;
          end else if (sync_wait) begin
            tmo_cnt <= '0;
          end else if (tmo_cnt == TMO_LAST) begin
            st <= B_ABORT;
          end else begin
            tmo_cnt <= tmo_cnt + 1'b1;
          end
        end
        B_RDATA: begin
          if (nib_cnt[0]) begin
            rbyte[7:4] <= lad_in;
            nib_cnt    <= '0;
            st         <= B_TARP;
          end else begin
            rbyte[3:0] <= lad_in;
            nib_cnt    <= nib_cnt + 1'b1;
          end
        end
        B_TARP: begin
          if (nib_cnt == TAR_LAST) begin
            nib_cnt <= '0;
            st      <= B_IDLE;
          end else begin
            nib_cnt <= nib_cnt + 1'b1;
          end
        end
        B_ABORT: st <= B_IDLE;
        default: st <= B_IDLE;
      endcase
    end
  end

  always_comb begin
    lad_out  = NIB_IDLE;
    lad_oe   = 1'b0;
    lframe_n = 1'b1;
    unique case (st)
      B_START: begin
        lad_out  = NIB_START;
        lad_oe   = 1'b1;
        lframe_n = 1'b0;
      end
      B_CTDIR: begin
        lad_out = cyc_nib(io, wr);
        lad_oe  = 1'b1;
      end
      B_ADDR: begin
        lad_out = a_shift[3:0];
        lad_oe  = 1'b1;
      end
      B_WDATA: begin
        lad_out = nib_cnt[0] ? wdata[7:4] : wdata[3:0];
        lad_oe  = 1'b1;
      end
      B_ABORT: begin
        lad_out  = NIB_ABORT;
        lad_oe   = 1'b1;
        lframe_n = 1'b0;
      end
      default: ;
    endcase
  end

  assign byte_done  = (st == B_ABORT) || ((st == B_TARP) && (nib_cnt == TAR_LAST));
  assign byte_rdata = (st == B_ABORT) ? 8'hFF : rbyte;

  // R9: framing strobe carries only the start or abort nibble
  a_r9_frame_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    !lframe_n |-> (lad_oe && (lad_out == NIB_START || lad_out == NIB_ABORT)));

  // R6: a wait nibble keeps the cycle in sync
  a_r6_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (st == B_SYNC && sync_wait) |=> (st == B_SYNC));

  // R7: abort only follows a silent sync clock
  a_r7_abort_after_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (st == B_ABORT) |-> ($past(st) == B_SYNC && !$past(sync_ok)));

  // R5: the host is off the bus while the peripheral owns it
  a_r5_float_when_peripheral: assert property (@(posedge clk) disable iff (!rst_n)
    (st == B_SYNC || st == B_RDATA || st == B_TARP || st == B_TARH) |-> !lad_oe);

endmodule

// File: rtl/lpc_cycle_splitter.sv
module lpc_cycle_splitter
  import lpc_split_pkg::*;
#(
  parameter int ADDR_W       = 32,
  parameter int DATA_W       = 32,
  parameter int SYNC_TIMEOUT = 4,
  parameter int TAR_CLKS     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_io,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              cpl_valid,
  output logic [DATA_W-1:0] cpl_rdata,
  output logic [3:0]        lad_out,
  output logic              lad_oe,
  input  logic [3:0]        lad_in,
  output logic              lframe_n,
  input  logic [1:0]        bm_size,
  input  logic [1:0]        bm_addr,
  output logic              bm_misaligned
);

  localparam int NBYTES = DATA_W / 8;
  localparam int IDX_W  = $clog2(NBYTES);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(NBYTES - 1);

  logic              active;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  last;
  logic [IDX_W-1:0]  size_last;
  logic              io_q;
  logic              wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              accept;
  logic              byte_done;
  logic [7:0]        byte_rdata;
  logic [ADDR_W-1:0] byte_addr;
  logic [7:0]        byte_wdata;
  logic              final_byte;

  assign req_ready  = !active;
  assign accept     = req_valid && req_ready;
  assign byte_addr  = addr_q + ADDR_W'(idx);
  assign byte_wdata = wdata_q[idx*8 +: 8];
  assign final_byte = byte_done && (idx == last);

  always_comb begin
    unique case (req_size)
      2'b00:   size_last = '0;
      2'b01:   size_last = IDX_W'(1);
      default: size_last = IDX_MAX;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      idx       <= '0;
      last      <= '0;
      io_q      <= 1'b0;
      wr_q      <= 1'b0;
      addr_q    <= '0;
      wdata_q   <= '0;
      cpl_valid <= 1'b0;
    end else begin
      cpl_valid <= final_byte;
      if (accept) begin
        active  <= 1'b1;
        idx     <= '0;
        last    <= size_last;
        io_q    <= req_io;
        wr_q    <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end else if (byte_done) begin
        if (idx == last) active <= 1'b0;
        else             idx    <= idx + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                            lane_q <= '0;
      else if (accept)                                       lane_q <= '0;
      else if (byte_done && !wr_q && idx == IDX_W'(i))      lane_q <= byte_rdata;
    end
    assign cpl_rdata[i*8 +: 8] = lane_q;
  end

  lpc_byte_engine #(
    .ADDR_W   (ADDR_W),
    .TIMEOUT  (SYNC_TIMEOUT),
    .TAR_CLKS (TAR_CLKS)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (active),
    .io         (io_q),
    .wr         (wr_q),
    .addr       (byte_addr),
    .wdata      (byte_wdata),
    .lad_in     (lad_in),
    .lad_out    (lad_out),
    .lad_oe     (lad_oe),
    .lframe_n   (lframe_n),
    .byte_done  (byte_done),
    .byte_rdata (byte_rdata)
  );

  lpc_align_check u_align (
    .size       (bm_size),
    .addr_lo    (bm_addr),
    .misaligned (bm_misaligned)
  );

  // R8: completion is a single-clock pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |=> !cpl_valid);

  // R1: taking a request closes the port until completion
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R11: completion always reopens the request port
  a_r11_ready_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> req_ready);

endmodule

// File: tb/lpc_cycle_splitter_test.sv
module lpc_cycle_splitter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_io = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'b00;
  logic [31:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        cpl_valid;
  logic [31:0] cpl_rdata;
  logic [3:0]  lad_out;
  logic        lad_oe;
  logic [3:0]  lad_in = 4'hF;
  logic        lframe_n;
  logic [1:0]  bm_size = '0;
  logic [1:0]  bm_addr = '0;
  logic        bm_misaligned;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lpc_cycle_splitter uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_io(req_io), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .cpl_valid(cpl_valid), .cpl_rdata(cpl_rdata),
    .lad_out(lad_out), .lad_oe(lad_oe), .lad_in(lad_in), .lframe_n(lframe_n),
    .bm_size(bm_size), .bm_addr(bm_addr), .bm_misaligned(bm_misaligned)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- peripheral model ----------------
  bit        claim = 1;
  int        waits = 0;
  int        p_st = 0;
  int        p_nib = 0;
  int        p_anibs = 0;
  int        p_wleft = 0;
  logic [3:0]  p_ct;
  logic [31:0] p_addr;
  logic [7:0]  p_wd;
  logic [7:0]  p_rd;
  logic [3:0]  log_ct   [64];
  logic [31:0] log_addr [64];
  logic [7:0]  log_wd   [64];
  int nlog = 0;
  int n_abort = 0;
  int oe_err = 0;
  int frame_err = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!lframe_n && !(lad_oe && (lad_out == 4'h0 || lad_out == 4'hF))) frame_err++;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      p_st = 0;
      lad_in = 4'hF;
    end else begin
      case (p_st)
        0: begin
          lad_in = 4'hF;
          if (!lframe_n && lad_out == 4'h0) p_st = 1;
          else if (!lframe_n && lad_out == 4'hF) n_abort++;
        end
        1: begin
          p_ct = lad_out; p_addr = '0; p_nib = 0; p_wd = '0;
          p_anibs = lad_out[2] ? 8 : 4;
          p_st = 2;
        end
        2: begin
          p_addr = {p_addr[27:0], lad_out};
          p_nib++;
          if (p_nib == p_anibs) begin
            p_nib = 0;
            p_st = p_ct[1] ? 3 : 4;
          end
        end
        3: begin
          if (p_nib == 0) begin p_wd[3:0] = lad_out; p_nib = 1; end
          else begin p_wd[7:4] = lad_out; p_nib = 0; p_st = 4; end
        end
        4: begin
          if (lad_oe) oe_err++;
          p_nib++;
          if (p_nib == 2) begin
            p_nib = 0;
            if (nlog < 64) begin
              log_ct[nlog] = p_ct; log_addr[nlog] = p_addr; log_wd[nlog] = p_wd;
            end
            nlog++;
            if (claim) begin p_st = 5; p_wleft = waits; end
            else p_st = 0;
          end
        end
        5: begin
          if (lad_oe) oe_err++;
          if (p_wleft > 0) begin
            lad_in = p_wleft[0] ? 4'h5 : 4'h6;
            p_wleft--;
          end else begin
            lad_in = 4'h0;
            p_rd = p_addr[7:0] ^ 8'h5A;
            p_st = p_ct[1] ? 7 : 6;
          end
        end
        6: begin
          if (lad_oe) oe_err++;
          if (p_nib == 0) begin lad_in = p_rd[3:0]; p_nib = 1; end
          else begin lad_in = p_rd[7:4]; p_nib = 0; p_st = 7; end
        end
        7: begin
          if (lad_oe) oe_err++;
          lad_in = 4'hF;
          p_nib++;
          if (p_nib == 2) begin p_nib = 0; p_st = 0; end
        end
        default: p_st = 0;
      endcase
    end
  end

  function automatic logic [7:0] rd_of(input logic [31:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  // ---------------- request helpers ----------------
  task automatic offer(input bit io, input bit wr, input logic [1:0] sz,
                       input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    req_io = io; req_write = wr; req_size = sz; req_addr = a; req_wdata = d;
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_cpl(output logic [31:0] rd, input string tag);
    int n = 0;
    while (!cpl_valid && n < 2000) begin @(negedge clk); n++; end
    rd = cpl_rdata;
    chk(cpl_valid, tag, {31'b0, cpl_valid}, 32'h1);
    @(negedge clk);
    chk(!cpl_valid, "R8 single-clock completion", {31'b0, cpl_valid}, 32'h0);
  endtask

  task automatic chk_byte(input int k, input logic [3:0] ct, input logic [31:0] a,
                          input logic [7:0] d, input bit wr, input string tag);
    chk(log_ct[k] == ct, {tag, " type nibble (R3)"}, {28'b0, log_ct[k]}, {28'b0, ct});
    chk(log_addr[k] == a, {tag, " address (R4)"}, log_addr[k], a);
    if (wr) chk(log_wd[k] == d, {tag, " write byte (R2)"}, {24'b0, log_wd[k]}, {24'b0, d});
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset;
    chk(req_ready, "R1 ready after reset", {31'b0, req_ready}, 32'h1);
    chk(!cpl_valid, "R8 no completion after reset", {31'b0, cpl_valid}, 32'h0);
    chk(lframe_n && !lad_oe, "R9 bus quiet after reset", {30'b0, lframe_n, lad_oe}, 32'h2);
  endtask

  task automatic t_io_write;
    logic [31:0] rd;
    int b = nlog;
    claim = 1; waits = 0;
    offer(1, 1, 2'b00, 32'h0001_02E4, 32'h0000_00A7);
    wait_cpl(rd, "R3 io write completes");
    chk(nlog - b == 1, "R2 one byte cycle", nlog - b, 1);
    chk_byte(b, 4'b0010, 32'h0000_02E4, 8'hA7, 1, "R4 io write");
    chk(rd == 0, "R8 write returns zero", rd, 0);
  endtask

  task automatic t_mem_read4;
    logic [31:0] rd;
    int b = nlog;
    claim = 1; waits = 0;
    offer(0, 0, 2'b10, 32'h000F_1230, 32'h0);
    wait_cpl(rd, "R2 mem read completes");
    chk(nlog - b == 4, "R2 four byte cycles", nlog - b, 4);
    for (int i = 0; i < 4; i++)
      chk_byte(b + i, 4'b0100, 32'h000F_1230 + i, 8'h0, 0, "R2 mem read");
    chk(rd == {rd_of(32'h33), rd_of(32'h32), rd_of(32'h31), rd_of(32'h30)},
        "R8 little-endian packing", rd,
        {rd_of(32'h33), rd_of(32'h32), rd_of(32'h31), rd_of(32'h30)});
  endtask

  task automatic t_mem_write2;
    logic [31:0] rd;
    int b = nlog;
    claim = 1; waits = 0;
    offer(0, 1, 2'b01, 32'h0000_0100, 32'h1234_BEEF);
    wait_cpl(rd, "R2 mem write completes");
    chk(nlog - b == 2, "R2 two byte cycles", nlog - b, 2);
    chk_byte(b,     4'b0110, 32'h100, 8'hEF, 1, "R2 byte0");
    chk_byte(b + 1, 4'b0110, 32'h101, 8'hBE, 1, "R2 byte1");
  endtask

  task automatic t_size3_write;
    logic [31:0] rd;
    int b = nlog;
    offer(1, 1, 2'b11, 32'h0000_0080, 32'hDDCC_BBAA);
    wait_cpl(rd, "R2 size 11 completes");
    chk(nlog - b == 4, "R2 size 11 gives four cycles", nlog - b, 4);
    chk_byte(b + 3, 4'b0010, 32'h83, 8'hDD, 1, "R2 size 11 last byte");
  endtask

  task automatic t_long_wait;
    logic [31:0] rd;
    int a0 = n_abort;
    claim = 1; waits = 7;
    offer(1, 0, 2'b00, 32'h0000_0061, 32'h0);
    wait_cpl(rd, "R6 waited read completes");
    chk(n_abort == a0, "R6 waits do not abort", n_abort - a0, 0);
    chk(rd == {24'b0, rd_of(32'h61)}, "R6 data after waits", rd, {24'b0, rd_of(32'h61)});
    waits = 0;
  endtask

  task automatic t_unclaimed;
    logic [31:0] rd;
    int a0 = n_abort;
    int b = nlog;
    claim = 0;
    offer(0, 0, 2'b01, 32'h0000_0C00, 32'h0);
    wait_cpl(rd, "R7 unclaimed read completes");
    chk(n_abort - a0 == 2, "R7 one abort per byte", n_abort - a0, 2);
    chk(nlog - b == 2, "R7 next byte still issued", nlog - b, 2);
    chk(rd == 32'h0000_FFFF, "R7 all-ones data", rd, 32'h0000_FFFF);
    claim = 1;
  endtask

  task automatic t_busy_ignore;
    logic [31:0] rd;
    int b = nlog;
    offer(0, 1, 2'b00, 32'h0000_0500, 32'h11);
    @(negedge clk);
    req_addr = 32'h700; req_wdata = 32'h22; req_valid = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!req_ready, "R1 not ready while busy", {31'b0, req_ready}, 32'h0);
    end
    req_valid = 1'b0;
    wait_cpl(rd, "R1 busy request completes");
    repeat (30) @(negedge clk);
    chk(nlog - b == 1, "R1 busy offer ignored", nlog - b, 1);
    chk_byte(b, 4'b0110, 32'h500, 8'h11, 1, "R1 original request");
  endtask

  task automatic t_overlap;
    int b;
    int n = 0;
    offer(1, 0, 2'b00, 32'h0000_0060, 32'h0);
    b = nlog;
    req_io = 0; req_write = 1; req_size = 2'b00;
    req_addr = 32'h0000_3000; req_wdata = 32'h99;
    req_valid = 1'b1;
    while (!cpl_valid && n < 2000) begin @(negedge clk); n++; end
    chk(req_ready && cpl_valid, "R11 accept in completion clock",
        {30'b0, req_ready, cpl_valid}, 32'h3);
    chk(cpl_rdata == {24'b0, rd_of(32'h60)}, "R11 first read data", cpl_rdata,
        {24'b0, rd_of(32'h60)});
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R11 second request taken", {31'b0, req_ready}, 32'h0);
    n = 0;
    while (!cpl_valid && n < 2000) begin @(negedge clk); n++; end
    chk(cpl_valid, "R11 second completes", {31'b0, cpl_valid}, 32'h1);
    @(negedge clk);
    chk(nlog - b == 2, "R11 both cycles on bus", nlog - b, 2);
    chk_byte(b + 1, 4'b0110, 32'h3000, 8'h99, 1, "R11 second request");
  endtask

  task automatic t_align;
    for (int s = 0; s < 4; s++) begin
      for (int a = 0; a < 4; a++) begin
        logic exp;
        bm_size = s[1:0]; bm_addr = a[1:0];
        exp = (s == 0) ? 1'b0 : (s == 1) ? a[0] : (a != 0);
        #1;
        chk(bm_misaligned == exp, "R10 alignment flag", {31'b0, bm_misaligned}, {31'b0, exp});
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_io_write();
    t_mem_read4();
    t_mem_write2();
    t_size3_write();
    t_long_wait();
    t_unclaimed();
    t_busy_ignore();
    t_overlap();
    t_align();
    chk(frame_err == 0, "R9 framing strobe nibbles", frame_err, 0);
    chk(oe_err == 0, "R5 host off bus in peripheral phases", oe_err, 0);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule